// File: doc/BRIEF.md
# USB Endpoint Event and Mask Register Bank

This block captures endpoint activity events for a full-speed USB function controller and presents them to a local processor as byte-wide registers. It tracks four kinds of event. The first is receive completion on four receive FIFOs. The second is receive overrun on those same FIFOs. The third is NAK handshakes sent for IN and OUT tokens on four endpoints. The fourth is fill-level warnings on three transmit FIFOs and three receive FIFOs. The endpoint engines report each event as a single-cycle pulse, and the block holds it in a sticky bit until the clear rule for that bit fires.

Each event register has a companion mask register with the same bit layout. A summary output is high while any event bit is set and its mask bit is set. The summary outputs feed the main event register of the controller. Different bits use different clear rules. Overrun and NAK bits clear when their register is read. Completion bits clear on a read of the matching receive status register, which this block sees as a strobe input. Warning bits clear on FIFO activity and never on a read.

Top module: `usb_evt_regs`

## Requirements
- R1: After reset, every event and mask register reads 0x00, and `rx_ev_sum`, `nak_sum` and `fw_sum` are low.
- R2: The receive event register is at address 0. Bits 3:0 are the per-FIFO completion bits. For FIFOs 1 to 3, the completion bit sets on a `rx_last` pulse or on a `rx_err` pulse.
- R3: For FIFO 0, the completion bit sets only on `rx_last[0]`. A `rx_err[0]` pulse alone leaves it clear.
- R4: A completion bit clears on a `rx_stat_rd` pulse for its FIFO. Reading address 0 does not clear it.
- R5: Bits 7:4 of address 0 are the overrun bits. They set on `rx_ov` pulses, and all of them clear when address 0 is read.
- R6: The NAK event register is at address 2. IN NAK bits are in bits 3:0 and OUT NAK bits are in bits 7:4. A bit sets only while `dev_addr_en` is high and `ep_en` is high for that endpoint. Reading address 2 clears the whole register.
- R7: An OUT NAK pulse that comes with `nak_ov` for the same endpoint does not set the OUT bit. An IN NAK pulse still sets its IN bit while `nak_ov` is high.
- R8: The warning register is at address 4. Bits 3:1 are transmit FIFOs 1 to 3 and bits 7:5 are receive FIFOs 1 to 3. Bits 0 and 4 read as 0. A transmit warning bit sets on `tx_wrn_hit` while `tx_en` is high for that FIFO. It clears on `tx_push`, `tx_flush` or `tx_done`. Reading the register does not clear it.
- R9: A receive warning bit sets on `rx_wrn_hit` while `rx_en` is high for that FIFO, and clears on `rx_pop` or `rx_flush`.
- R10: The mask registers are at addresses 1 (receive), 3 (NAK) and 5 (warning) and can be written and read back. In the warning mask, bits 0 and 4 read as 0. Writes to addresses 0, 2 and 4 have no effect.
- R11: `rx_ev_sum`, `nak_sum` and `fw_sum` are high exactly while their event register ANDed with its mask is nonzero. They follow the register state in the cycle after it changes.
- R12: When a set and a clear hit the same bit in the same cycle, the set wins and the bit stays 1.
- R13: Addresses 6 and 7 read as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Register address |
| reg_rd | input | 1 | Read strobe; read side effects take effect at the clock edge |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register (combinational) |
| rx_last | input | 4 | Per receive FIFO: last-byte flag was set |
| rx_err | input | 4 | Per receive FIFO: error flag was set |
| rx_ov | input | 4 | Per receive FIFO: overrun occurred |
| rx_stat_rd | input | 4 | Per receive FIFO: its status register was read |
| nak_in | input | 4 | Per endpoint: NAK sent for an IN token |
| nak_out | input | 4 | Per endpoint: NAK sent for an OUT token |
| nak_ov | input | 4 | Per endpoint: the NAK was caused by a receive overrun |
| dev_addr_en | input | 1 | Device address enabled |
| ep_en | input | 4 | Per endpoint enable |
| tx_wrn_hit | input | 3 | Transmit FIFOs 1-3 reached the warning limit |
| tx_en | input | 3 | Transmit enabled on FIFOs 1-3 |
| tx_push | input | 3 | New data written to transmit FIFOs 1-3 |
| tx_flush | input | 3 | Transmit FIFOs 1-3 flushed |
| tx_done | input | 3 | Transmit-done flag for FIFOs 1-3 |
| rx_wrn_hit | input | 3 | Receive FIFOs 1-3 reached the warning limit |
| rx_en | input | 3 | Receive enabled on FIFOs 1-3 |
| rx_pop | input | 3 | Data read from receive FIFOs 1-3 |
| rx_flush | input | 3 | Receive FIFOs 1-3 flushed |
| rx_ev_sum | output | 1 | Receive summary: receive events AND receive mask is nonzero |
| nak_sum | output | 1 | NAK summary: NAK events AND NAK mask is nonzero |
| fw_sum | output | 1 | Warning summary: warning events AND warning mask is nonzero |

## Verification
The hardest case to reach is a read-clear that lands in the same cycle as a new event on another bit of the same register. In that cycle, the read must return the old image, the old bits must drop, and the new bit must survive. The bench drives an overrun pulse while it issues the read of address 0. It checks the value returned by that read, then reads again and expects only the new bit. The bench also checks the warning registers with a limit hit that coincides with a FIFO push, and it checks that an error-only completion on FIFO 0 is ignored in between valid completions.

// File: rtl/usb_evt_pkg.sv
package usb_evt_pkg;
   localparam int REG_AW = 3;
   localparam int BYTE_W = 8;
   localparam int NIB_W  = 4;

   localparam logic [REG_AW-1:0] A_RX_EV  = 3'd0;
   localparam logic [REG_AW-1:0] A_RX_MSK = 3'd1;
   localparam logic [REG_AW-1:0] A_NK_EV  = 3'd2;
   localparam logic [REG_AW-1:0] A_NK_MSK = 3'd3;
   localparam logic [REG_AW-1:0] A_FW_EV  = 3'd4;
   localparam logic [REG_AW-1:0] A_FW_MSK = 3'd5;
endpackage

// File: rtl/evt_latch.sv
module evt_latch #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] q_o
);
   if (W < 1) begin : g_bad_w
      $error("evt_latch: W must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) q_o <= '0;
      else        q_o <= (q_o & ~clr_i) | set_i;
   end

   // R12
   set_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i != '0) |=> ((q_o & $past(set_i)) == $past(set_i)));

   // R4
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i == '0) |=> ((q_o & $past(q_o)) == $past(q_o)));
endmodule

// File: rtl/fifo_warn.sv
module fifo_warn #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] hit_i,
   input  logic [N-1:0] en_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] q_o
);
   logic [N-1:0] qual_set;

   assign qual_set = hit_i & en_i;

   evt_latch #(.W(N)) u_lat (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (qual_set),
      .clr_i (clr_i),
      .q_o   (q_o)
   );

   // R8 R9: a limit hit on a disabled FIFO never raises its bit
   no_unqual_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((q_o & $past(~q_o & ~(hit_i & en_i))) == '0));
endmodule

// File: rtl/usb_evt_regs.sv
module usb_evt_regs
   import usb_evt_pkg::*;
#(
   parameter int N_RX   = 4,
   parameter int N_NAK  = 4,
   parameter int N_WARN = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [REG_AW-1:0]   reg_addr,
   input  logic                reg_rd,
   input  logic                reg_wr,
   input  logic [BYTE_W-1:0]   reg_wdata,
   output logic [BYTE_W-1:0]   reg_rdata,
   input  logic [N_RX-1:0]     rx_last,
   input  logic [N_RX-1:0]     rx_err,
   input  logic [N_RX-1:0]     rx_ov,
   input  logic [N_RX-1:0]     rx_stat_rd,
   input  logic [N_NAK-1:0]    nak_in,
   input  logic [N_NAK-1:0]    nak_out,
   input  logic [N_NAK-1:0]    nak_ov,
   input  logic                dev_addr_en,
   input  logic [N_NAK-1:0]    ep_en,
   input  logic [N_WARN-1:0]   tx_wrn_hit,
   input  logic [N_WARN-1:0]   tx_en,
   input  logic [N_WARN-1:0]   tx_push,
   input  logic [N_WARN-1:0]   tx_flush,
   input  logic [N_WARN-1:0]   tx_done,
   input  logic [N_WARN-1:0]   rx_wrn_hit,
   input  logic [N_WARN-1:0]   rx_en,
   input  logic [N_WARN-1:0]   rx_pop,
   input  logic [N_WARN-1:0]   rx_flush,
   output logic                rx_ev_sum,
   output logic                nak_sum,
   output logic                fw_sum
);
   localparam int HI_LANE = NIB_W;
   localparam int TXW_LO  = 1;
   localparam int RXW_LO  = NIB_W + 1;

   if (N_RX < 1 || N_RX > NIB_W) begin : g_bad_rx
      $error("usb_evt_regs: N_RX must be 1..4");
   end
   if (N_NAK < 1 || N_NAK > NIB_W) begin : g_bad_nak
      $error("usb_evt_regs: N_NAK must be 1..4");
   end
   if (N_WARN < 1 || N_WARN > NIB_W - 1) begin : g_bad_warn
      $error("usb_evt_regs: N_WARN must be 1..3");
   end

   // read strobes with side effects
   logic rd_rx_ev, rd_nk_ev;
   assign rd_rx_ev = reg_rd && (reg_addr == A_RX_EV);
   assign rd_nk_ev = reg_rd && (reg_addr == A_NK_EV);

   // receive completion: FIFO 0 ignores error-only completions
   logic [N_RX-1:0] rxf_set, rxf_q, rxo_q;
   for (genvar i = 0; i < N_RX; i++) begin : g_rxf
      if (i == 0) begin : g_ep0
         assign rxf_set[i] = rx_last[i];
      end else begin : g_epn
         assign rxf_set[i] = rx_last[i] | rx_err[i];
      end
   end

   evt_latch #(.W(N_RX)) u_rxf (
      .clk(clk), .rst_n(rst_n), .set_i(rxf_set), .clr_i(rx_stat_rd), .q_o(rxf_q));

   evt_latch #(.W(N_RX)) u_rxo (
      .clk(clk), .rst_n(rst_n), .set_i(rx_ov), .clr_i({N_RX{rd_rx_ev}}), .q_o(rxo_q));

   // NAK capture, gated by address and endpoint enables
   logic [N_NAK-1:0] nk_gate, nki_set, nko_set, nki_q, nko_q;
   assign nk_gate = ep_en & {N_NAK{dev_addr_en}};
   assign nki_set = nak_in & nk_gate;
   assign nko_set = nak_out & nk_gate & ~nak_ov;

   evt_latch #(.W(N_NAK)) u_nki (
      .clk(clk), .rst_n(rst_n), .set_i(nki_set), .clr_i({N_NAK{rd_nk_ev}}), .q_o(nki_q));

   evt_latch #(.W(N_NAK)) u_nko (
      .clk(clk), .rst_n(rst_n), .set_i(nko_set), .clr_i({N_NAK{rd_nk_ev}}), .q_o(nko_q));

   // FIFO warnings clear on FIFO activity only
   logic [N_WARN-1:0] txw_q, rxw_q;

   fifo_warn #(.N(N_WARN)) u_txw (
      .clk(clk), .rst_n(rst_n), .hit_i(tx_wrn_hit), .en_i(tx_en),
      .clr_i(tx_push | tx_flush | tx_done), .q_o(txw_q));

   fifo_warn #(.N(N_WARN)) u_rxw (
      .clk(clk), .rst_n(rst_n), .hit_i(rx_wrn_hit), .en_i(rx_en),
      .clr_i(rx_pop | rx_flush), .q_o(rxw_q));

   // byte images and implemented-bit masks
   logic [BYTE_W-1:0] rx_img, nk_img, fw_img;
   logic [BYTE_W-1:0] rx_ok, nk_ok, fw_ok;

   always_comb begin
      rx_img = '0; nk_img = '0; fw_img = '0;
      rx_ok  = '0; nk_ok  = '0; fw_ok  = '0;
      rx_img[N_RX-1:0]          = rxf_q;
      rx_img[HI_LANE +: N_RX]   = rxo_q;
      rx_ok[N_RX-1:0]           = '1;
      rx_ok[HI_LANE +: N_RX]    = '1;
      nk_img[N_NAK-1:0]         = nki_q;
      nk_img[HI_LANE +: N_NAK]  = nko_q;
      nk_ok[N_NAK-1:0]          = '1;
      nk_ok[HI_LANE +: N_NAK]   = '1;
      fw_img[TXW_LO +: N_WARN]  = txw_q;
      fw_img[RXW_LO +: N_WARN]  = rxw_q;
      fw_ok[TXW_LO +: N_WARN]   = '1;
      fw_ok[RXW_LO +: N_WARN]   = '1;
   end

   // mask registers
   logic [BYTE_W-1:0] rx_msk, nk_msk, fw_msk;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rx_msk <= '0;
         nk_msk <= '0;
         fw_msk <= '0;
      end else if (reg_wr) begin
         if (reg_addr == A_RX_MSK) rx_msk <= reg_wdata & rx_ok;
         if (reg_addr == A_NK_MSK) nk_msk <= reg_wdata & nk_ok;
         if (reg_addr == A_FW_MSK) fw_msk <= reg_wdata & fw_ok;
      end
   end

   // read mux
   always_comb begin
      case (reg_addr)
         A_RX_EV:  reg_rdata = rx_img;
         A_RX_MSK: reg_rdata = rx_msk;
         A_NK_EV:  reg_rdata = nk_img;
         A_NK_MSK: reg_rdata = nk_msk;
         A_FW_EV:  reg_rdata = fw_img;
         A_FW_MSK: reg_rdata = fw_msk;
         default:  reg_rdata = '0;
      endcase
   end

   // summary levels
   assign rx_ev_sum = |(rx_img & rx_msk);
   assign nak_sum   = |(nk_img & nk_msk);
   assign fw_sum    = |(fw_img & fw_msk);

   // R3
   ep0_err_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rxf_q[0] && !rx_last[0]) |=> !rxf_q[0]);

   // R5
   ovr_rdclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_rx_ev && (rx_ov == '0)) |=> (rxo_q == '0));

   // R6
   nak_rdclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_nk_ev && (nak_in == '0) && (nak_out == '0)) |=> ((nki_q == '0) && (nko_q == '0)));

   // R7
   for (genvar k = 0; k < N_NAK; k++) begin : g_nko_chk
      out_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!nko_q[k] && nak_ov[k]) |=> !nko_q[k]);
   end
endmodule

// File: tb/usb_evt_regs_tb_top.sv
module usb_evt_regs_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] reg_addr = '0;
   logic       reg_rd = 1'b0, reg_wr = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic [3:0] rx_last = '0, rx_err = '0, rx_ov = '0, rx_stat_rd = '0;
   logic [3:0] nak_in = '0, nak_out = '0, nak_ov = '0, ep_en = '0;
   logic       dev_addr_en = 1'b0;
   logic [2:0] tx_wrn_hit = '0, tx_en = '0, tx_push = '0, tx_flush = '0, tx_done = '0;
   logic [2:0] rx_wrn_hit = '0, rx_en = '0, rx_pop = '0, rx_flush = '0;
   logic       rx_ev_sum, nak_sum, fw_sum;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;
   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #2 clk = ~clk;

   usb_evt_regs dut_i (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .rx_last(rx_last), .rx_err(rx_err), .rx_ov(rx_ov), .rx_stat_rd(rx_stat_rd),
      .nak_in(nak_in), .nak_out(nak_out), .nak_ov(nak_ov), .dev_addr_en(dev_addr_en),
      .ep_en(ep_en), .tx_wrn_hit(tx_wrn_hit), .tx_en(tx_en), .tx_push(tx_push),
      .tx_flush(tx_flush), .tx_done(tx_done), .rx_wrn_hit(rx_wrn_hit), .rx_en(rx_en),
      .rx_pop(rx_pop), .rx_flush(rx_flush),
      .rx_ev_sum(rx_ev_sum), .nak_sum(nak_sum), .fw_sum(fw_sum));

   task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, got, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); #1;
   endtask

   // driver: issue a read and push the expected value to the scoreboard
   task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
      reg_addr = a;
      reg_rd   = 1'b1;
      exp_q.push_back(e);
      tag_q.push_back(tag);
      tick();
      reg_rd = 1'b0;
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      reg_addr  = a;
      reg_wdata = d;
      reg_wr    = 1'b1;
      tick();
      reg_wr = 1'b0;
   endtask

   // monitor: compare read data away from the active edge
   always @(negedge clk) begin
      if (reg_rd && exp_q.size() > 0) begin
         logic [7:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         chk(reg_rdata, e, t);
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   initial begin
      #800000;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      for (int a = 0; a < 6; a++) rd(3'(a), 8'h00, "R1 reset value");
      chk({5'd0, rx_ev_sum, nak_sum, fw_sum}, 8'h00, "R1 summaries low");

      // R2 completion on FIFOs 1..3
      rx_last[2] = 1'b1; tick(); rx_last = '0;
      rd(3'd0, 8'h04, "R2 last sets fifo2");
      rx_err[1] = 1'b1; tick(); rx_err = '0;
      rd(3'd0, 8'h06, "R2 error sets fifo1");
      rd(3'd0, 8'h06, "R4 event read keeps completion bits");

      // R3 FIFO 0 ignores error-only completion
      rx_err[0] = 1'b1; tick(); rx_err = '0;
      rd(3'd0, 8'h06, "R3 fifo0 error ignored");
      rx_last[0] = 1'b1; tick(); rx_last = '0;
      rd(3'd0, 8'h07, "R3 fifo0 last sets");

      // R4 status-read clears
      rx_stat_rd[1] = 1'b1; tick(); rx_stat_rd = '0;
      rd(3'd0, 8'h05, "R4 status read clears fifo1");
      rx_stat_rd = 4'b0101; tick(); rx_stat_rd = '0;
      rd(3'd0, 8'h00, "R4 status read clears fifo0 fifo2");

      // R5 overrun and clear on read
      rx_ov[3] = 1'b1; tick(); rx_ov = '0;
      rd(3'd0, 8'h80, "R5 overrun sets");
      rd(3'd0, 8'h00, "R5 overrun cleared by read");
      rx_last[1] = 1'b1; rx_ov[0] = 1'b1; tick(); rx_last = '0; rx_ov = '0;
      rd(3'd0, 8'h12, "R5 overrun with completion");
      rd(3'd0, 8'h02, "R5 read clears only overrun");
      rx_stat_rd[1] = 1'b1; tick(); rx_stat_rd = '0;

      // R12 set beside read-clear
      rx_ov[2] = 1'b1; tick(); rx_ov = '0;
      rx_ov[1] = 1'b1;
      rd(3'd0, 8'h40, "R12 read returns old image");
      rx_ov = '0;
      rd(3'd0, 8'h20, "R12 new overrun survives read");
      rx_ov[1] = 1'b1;
      rd(3'd0, 8'h00, "R12 read while same bit sets");
      rx_ov = '0;
      rd(3'd0, 8'h20, "R12 set wins over clear");

      // R6 NAK capture
      dev_addr_en = 1'b1; ep_en = 4'b0101;
      nak_in = 4'b1111; tick(); nak_in = '0;
      nak_out[2] = 1'b1; tick(); nak_out = '0;
      rd(3'd2, 8'h45, "R6 enabled endpoints only");
      rd(3'd2, 8'h00, "R6 cleared by read");
      dev_addr_en = 1'b0;
      nak_in[0] = 1'b1; tick(); nak_in = '0;
      rd(3'd2, 8'h00, "R6 address disabled");
      dev_addr_en = 1'b1;

      // R7 overrun-caused OUT NAK suppressed
      nak_ov[0] = 1'b1; nak_out[0] = 1'b1; nak_in[0] = 1'b1; tick();
      nak_ov = '0; nak_out = '0; nak_in = '0;
      rd(3'd2, 8'h01, "R7 out suppressed in kept");
      rd(3'd2, 8'h00, "R7 cleared");

      // R10 masks
      wr(3'd1, 8'hA5); rd(3'd1, 8'hA5, "R10 rx mask");
      wr(3'd3, 8'h3C); rd(3'd3, 8'h3C, "R10 nak mask");
      wr(3'd5, 8'hFF); rd(3'd5, 8'hEE, "R10 warn mask reserved bits");
      wr(3'd0, 8'hFF); rd(3'd0, 8'h00, "R10 rx event write ignored");
      wr(3'd2, 8'hFF); rd(3'd2, 8'h00, "R10 nak event write ignored");
      wr(3'd4, 8'hFF); rd(3'd4, 8'h00, "R10 warn event write ignored");

      // R11 summaries
      rx_last[1] = 1'b1; tick(); rx_last = '0;
      chk({7'd0, rx_ev_sum}, 8'h00, "R11 unmasked event no summary");
      rx_last[2] = 1'b1; tick(); rx_last = '0;
      chk({7'd0, rx_ev_sum}, 8'h01, "R11 masked event summary");
      wr(3'd1, 8'h00);
      chk({7'd0, rx_ev_sum}, 8'h00, "R11 mask cleared drops summary");
      rx_stat_rd = 4'b0110; tick(); rx_stat_rd = '0;
      nak_in[0] = 1'b1; tick(); nak_in = '0;
      chk({7'd0, nak_sum}, 8'h00, "R11 nak unmasked");
      nak_out[0] = 1'b1; tick(); nak_out = '0;
      chk({7'd0, nak_sum}, 8'h01, "R11 nak masked");
      rd(3'd2, 8'h11, "R11 nak image");
      chk({7'd0, nak_sum}, 8'h00, "R11 nak read drops summary");

      // R8 transmit warnings
      tx_en = 3'b011;
      tx_wrn_hit[2] = 1'b1; tick(); tx_wrn_hit = '0;
      rd(3'd4, 8'h00, "R8 disabled fifo ignored");
      tx_wrn_hit[0] = 1'b1; tick(); tx_wrn_hit = '0;
      chk({7'd0, fw_sum}, 8'h01, "R11 warn summary");
      tx_wrn_hit[1] = 1'b1; tick(); tx_wrn_hit = '0;
      rd(3'd4, 8'h06, "R8 tx warn bits");
      rd(3'd4, 8'h06, "R8 not cleared by read");
      tx_push[0] = 1'b1; tick(); tx_push = '0;
      rd(3'd4, 8'h04, "R8 push clears");
      tx_done[1] = 1'b1; tick(); tx_done = '0;
      rd(3'd4, 8'h00, "R8 done clears");
      tx_wrn_hit[0] = 1'b1; tick(); tx_wrn_hit = '0;
      tx_flush[0] = 1'b1; tick(); tx_flush = '0;
      rd(3'd4, 8'h00, "R8 flush clears");
      tx_wrn_hit[0] = 1'b1; tx_push[0] = 1'b1; tick(); tx_wrn_hit = '0; tx_push = '0;
      rd(3'd4, 8'h02, "R12 warn set wins over push");
      tx_flush[0] = 1'b1; tick(); tx_flush = '0;

      // R9 receive warnings
      rx_en = 3'b100;
      rx_wrn_hit[2] = 1'b1; tick(); rx_wrn_hit = '0;
      rx_wrn_hit[0] = 1'b1; tick(); rx_wrn_hit = '0;
      rd(3'd4, 8'h80, "R9 rx warn enabled only");
      rx_pop[2] = 1'b1; tick(); rx_pop = '0;
      rd(3'd4, 8'h00, "R9 pop clears");
      rx_wrn_hit[2] = 1'b1; tick(); rx_wrn_hit = '0;
      rx_flush[2] = 1'b1; tick(); rx_flush = '0;
      rd(3'd4, 8'h00, "R9 flush clears");

      // R13 undecoded addresses
      rd(3'd6, 8'h00, "R13 address 6");
      rd(3'd7, 8'h00, "R13 address 7");

      tick(); tick();
      finish_run();
   end
endmodule